// File: doc/BRIEF.md
# Cartridge I/O Page Decoder with Control Latch

This block is the bus front end of a plug-in peripheral on an 8-bit host bus. It watches the host's I/O-page select strobe, the read/write line, the phase-2 bus clock, the low address byte within the page and the data bus. From these it produces three things. The first is eight active-low chip selects for the first sixteen bytes of the page. The second is the enable and direction of the external data transceiver. The third is a small control register that gates the peripheral's clock input, clock output, interrupt and drum trigger mode.

The decoder ignores address bit 0, so each select line covers an even/odd pair of offsets. Offsets from 0x10 to 0xFF assert no select at all.

A host write to offset 0x0A loads the control register when phase-2 falls. Phase-2 is sampled by the block's own clock. The load takes effect at the first rising `clk` edge that sees phase-2 low after seeing it high on the edge before. The register bits mix polarities: some disables are active low and one is active high.

Top module: `cartIoFront`

## Requirements
- R1: `xcvrEnN` is low exactly while the page strobe `ioPageN` is low, and high otherwise.
- R2: `xcvrToHost` equals `rdWr`: 1 (read) drives data toward the host, 0 (write) drives data inward.
- R3: While `ioPageN` is low and the offset is 0x00–0x0F, exactly one select is low: bit index offset[3:1] of `selN`. At no time is more than one bit of `selN` low.
- R4: Both offsets of an even/odd pair (2k and 2k+1) assert the same select line k.
- R5: With `ioPageN` high, or with any offset from 0x10 to 0xFF, `selN` is all ones.
- R6: The register loads at the first `clk` rising edge where `phi2` is sampled 0, the edge before sampled it 1, and the page is active with `rdWr`=0 at offset 0x0A. The outputs change only after that edge.
- R7: Data bit 0 drives `clkOutDisN` (0 disables the clock output). Bit 1 drives `clkInDis` (1 disables the clock input). Bit 2 drives `irqDisN` (0 disables interrupts). Bit 3 drives `drumPulse` (0 latch/level mode, 1 pulse mode). Bits 7:4 are ignored.
- R8: The register holds its value on reads of 0x0A, on writes to any other offset, while the page is inactive, and on writes to 0x0A that see no phase-2 falling edge.
- R9: A synchronous `rst` sets `clkOutDisN`=1, `clkInDis`=0, `irqDisN`=1 and `drumPulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples phase-2 |
| rst | input | 1 | Synchronous reset, active high |
| ioPageN | input | 1 | I/O page select strobe, active low |
| rdWr | input | 1 | Host bus direction, 1 = read, 0 = write |
| phi2 | input | 1 | Host phase-2 bus clock |
| addr | input | 8 | Offset within the I/O page |
| dataIn | input | 8 | Host data bus (write data) |
| selN | output | 8 | Active-low pair selects for offsets 0x00–0x0F |
| xcvrEnN | output | 1 | Data transceiver enable, active low |
| xcvrToHost | output | 1 | Transceiver direction, 1 = toward host |
| clkOutDisN | output | 1 | Clock-output disable, active low |
| clkInDis | output | 1 | Clock-input disable, active high |
| irqDisN | output | 1 | Interrupt disable, active low |
| drumPulse | output | 1 | Drum trigger mode, 0 latch, 1 pulse |

## Verification
The decoder is exercised with every low offset in pairs, the boundary offsets 0x0F and 0x10, the top of the page, and an inactive strobe. These cases separate a decoder that uses bit 0 from one that skips it, and a range check that is missing from one that is present. The control register is written with distinct bit patterns that include set upper bits, so that swapped or mis-polarized fields show up. Reads, writes to the neighbouring offset 0x0B and writes with phase-2 held high tell a correct write qualifier apart from a loose one. Random bus cycles weighted toward 0x0A then mix all of these against a bench model of the register.

// File: rtl/cartIoPkg.sv
package cartIoPkg;

  // Strobes passed from the bus control to the datapath
  typedef struct packed {
    logic pageActive;   // page strobe asserted
    logic ctrlHit;      // page active and offset equals control offset
    logic latchCtrl;    // load control register on this clk edge
  } ioStrobes_t;

  // Control register layout, bit 3 down to bit 0 of the data bus
  typedef struct packed {
    logic drumPulse;    // 0 latch mode, 1 pulse mode
    logic irqDisN;      // 0 disables interrupts
    logic clkInDis;     // 1 disables clock input
    logic clkOutDisN;   // 0 disables clock output
  } ctrlBits_t;

  localparam int CTRL_W = $bits(ctrlBits_t);

  localparam ctrlBits_t CTRL_SAFE = '{
    drumPulse:  1'b0,
    irqDisN:    1'b1,
    clkInDis:   1'b0,
    clkOutDisN: 1'b1
  };

endpackage

// File: rtl/cartIoCtrl.sv
module cartIoCtrl
  import cartIoPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CTRL_OFFSET = 'h0A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ioPageN,
  input  logic              rdWr,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] addr,
  output ioStrobes_t        strobes
);

  logic phi2Prev;
  logic phi2Fall;

  always_ff @(posedge clk) begin
    if (rst) phi2Prev <= 1'b0;
    else     phi2Prev <= phi2;
  end

  assign phi2Fall = phi2Prev & ~phi2;

  always_comb begin
    strobes.pageActive = ~ioPageN;
    strobes.ctrlHit    = ~ioPageN && (addr == ADDR_W'(CTRL_OFFSET));
    strobes.latchCtrl  = strobes.ctrlHit && ~rdWr && phi2Fall;
  end

endmodule

// File: rtl/cartIoDatapath.sv
module cartIoDatapath
  import cartIoPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SEL_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ioStrobes_t           strobes,
  input  logic                 rdWr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [SEL_COUNT-1:0] selN,
  output logic                 xcvrEnN,
  output logic                 xcvrToHost,
  output ctrlBits_t            ctrlQ
);

  localparam int SEL_BITS = $clog2(SEL_COUNT);
  localparam int HI_LSB   = SEL_BITS + 1;

  logic                inRange;
  logic [SEL_BITS-1:0] pairIdx;
  logic                unusedDataHi;

  // Bit 0 is skipped, so a pair of offsets shares one select.
  // Everything above the decoded window blocks all selects.
  assign inRange = (addr[ADDR_W-1:HI_LSB] == '0);
  assign pairIdx = addr[SEL_BITS:1];

  for (genvar i = 0; i < SEL_COUNT; i++) begin : g_sel
    assign selN[i] = ~(strobes.pageActive && inRange &&
                       (pairIdx == SEL_BITS'(i)));
  end

  assign xcvrEnN    = ~strobes.pageActive;
  assign xcvrToHost = rdWr;

  always_ff @(posedge clk) begin
    if (rst)                    ctrlQ <= CTRL_SAFE;
    else if (strobes.latchCtrl) ctrlQ <= ctrlBits_t'(dataIn[CTRL_W-1:0]);
  end

  assign unusedDataHi = ^dataIn[DATA_W-1:CTRL_W];

endmodule

// File: rtl/cartIoFront.sv
module cartIoFront
  import cartIoPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ioPageN,
  input  logic       rdWr,
  input  logic       phi2,
  input  logic [7:0] addr,
  input  logic [7:0] dataIn,
  output logic [7:0] selN,
  output logic       xcvrEnN,
  output logic       xcvrToHost,
  output logic       clkOutDisN,
  output logic       clkInDis,
  output logic       irqDisN,
  output logic       drumPulse
);

  ioStrobes_t strobes;
  ctrlBits_t  ctrlQ;

  cartIoCtrl #(.ADDR_W(8), .CTRL_OFFSET('h0A)) u_ctrl (
    .clk(clk), .rst(rst), .ioPageN(ioPageN), .rdWr(rdWr),
    .phi2(phi2), .addr(addr), .strobes(strobes)
  );

  cartIoDatapath #(.ADDR_W(8), .DATA_W(8), .SEL_COUNT(8)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .rdWr(rdWr),
    .addr(addr), .dataIn(dataIn), .selN(selN), .xcvrEnN(xcvrEnN),
    .xcvrToHost(xcvrToHost), .ctrlQ(ctrlQ)
  );

  assign clkOutDisN = ctrlQ.clkOutDisN;
  assign clkInDis   = ctrlQ.clkInDis;
  assign irqDisN    = ctrlQ.irqDisN;
  assign drumPulse  = ctrlQ.drumPulse;

endmodule

// File: rtl/cartIoChecker.sv
module cartIoChecker (
  input logic       clk,
  input logic       rst,
  input logic       ioPageN,
  input logic       rdWr,
  input logic       phi2,
  input logic [7:0] addr,
  input logic [7:0] dataIn,
  input logic [7:0] selN,
  input logic       xcvrEnN,
  input logic       xcvrToHost,
  input logic       clkOutDisN,
  input logic       clkInDis,
  input logic       irqDisN,
  input logic       drumPulse
);

  logic       wrHit;
  logic [3:0] outBits;

  assign wrHit   = !ioPageN && !rdWr && (addr == 8'h0A);
  assign outBits = {drumPulse, irqDisN, clkInDis, clkOutDisN};

  p_xcvr_idle_r1: assert property (@(posedge clk) disable iff (rst)
    ioPageN |-> xcvrEnN);

  p_dir_r2: assert property (@(posedge clk) disable iff (rst)
    xcvrToHost == rdWr);

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~selN));

  p_no_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (ioPageN || addr[7:4] != 4'h0) |-> (selN == 8'hFF));

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(phi2) && !phi2 && wrHit) |=> (outBits == $past(dataIn[3:0])));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !($past(phi2) && !phi2 && wrHit) |=> $stable(outBits));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (outBits == 4'b0101));

endmodule

bind cartIoFront cartIoChecker u_chk (.*);

// File: tb/tb_cartIoFront.sv
module tb_cartIoFront;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ioPageN = 1'b1;
  logic       rdWr = 1'b1;
  logic       phi2 = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] selN;
  logic       xcvrEnN, xcvrToHost, clkOutDisN, clkInDis, irqDisN, drumPulse;

  int testsRun = 0;
  int testsFailed = 0;
  logic [3:0] expReg;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cartIoFront dut (.*);

  function automatic logic [7:0] expSel(input logic pageN, input logic [7:0] a);
    logic [7:0] s = 8'hFF;
    if (!pageN && a[7:4] == 4'h0) s[a[3:1]] = 1'b0;
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regOut();
    return {4'h0, drumPulse, irqDisN, clkInDis, clkOutDisN};
  endfunction

  task automatic checkComb(input string req);
    check({req, " sel"}, selN, expSel(ioPageN, addr));
    check({req, " en"}, {7'h0, xcvrEnN}, {7'h0, ioPageN});
    check({req, " dir"}, {7'h0, xcvrToHost}, {7'h0, rdWr});
  endtask

  // One bus cycle: phase-2 high, then optionally falls
  task automatic busCycle(input logic pageN, input logic [7:0] a, input logic rw,
                          input logic [7:0] d, input logic doFall, input string req);
    @(negedge clk);
    ioPageN = pageN; addr = a; rdWr = rw; dataIn = d; phi2 = 1'b1;
    #1 checkComb({req, "/R1/R2/R3/R5"});
    @(negedge clk);
    phi2 = doFall ? 1'b0 : 1'b1;
    #1 check({req, " R6 before edge"}, regOut(), {4'h0, expReg});
    @(negedge clk);
    if (doFall && !pageN && !rw && a == 8'h0A) expReg = d[3:0];
    #1 check({req, " R6/R7/R8 after edge"}, regOut(), {4'h0, expReg});
    ioPageN = 1'b1; phi2 = 1'b1;
  endtask

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    expReg = 4'b0101;
    repeat (3) @(negedge clk);
    #1 check("R9 reset state", regOut(), 8'h05);
    rst = 1'b0;

    // R4: pairs share a select
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); ioPageN = 1'b0; rdWr = 1'b1; addr = 8'(2*k);
      #1 check("R4 even", selN, ~(8'h01 << k));
      addr = 8'(2*k+1);
      #1 check("R4 odd", selN, ~(8'h01 << k));
    end
    // R5: boundaries and inactive page
    addr = 8'h10; #1 check("R5 offset 0x10", selN, 8'hFF);
    addr = 8'hFF; #1 check("R5 offset 0xFF", selN, 8'hFF);
    addr = 8'h0F; #1 check("R3 offset 0x0F", selN, 8'h7F);
    ioPageN = 1'b1; addr = 8'h04; #1 check("R5 page idle", selN, 8'hFF);
    #1 check("R1 idle enable", {7'h0, xcvrEnN}, 8'h01);

    // R7: field mapping with upper bits set
    busCycle(1'b0, 8'h0A, 1'b0, 8'hFA, 1'b1, "R7 write FA");
    check("R7 clkInDis bit1", {7'h0, clkInDis}, 8'h01);
    check("R7 drumPulse bit3", {7'h0, drumPulse}, 8'h01);
    busCycle(1'b0, 8'h0A, 1'b0, 8'h05, 1'b1, "R7 write 05");
    // R8: things that must not load
    busCycle(1'b0, 8'h0A, 1'b1, 8'h0A, 1'b1, "R8 read 0A");
    busCycle(1'b0, 8'h0B, 1'b0, 8'h0A, 1'b1, "R8 write 0B");
    busCycle(1'b1, 8'h0A, 1'b0, 8'h0A, 1'b1, "R8 page idle");
    busCycle(1'b0, 8'h0A, 1'b0, 8'h0A, 1'b0, "R8 no phi2 fall");
    check("R8 value kept", regOut(), 8'h05);
    busCycle(1'b0, 8'h0A, 1'b0, 8'h0A, 1'b1, "R6 write 0A");

    // Random cycles weighted toward the control offset
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      logic [31:0] r = $urandom;
      a = (r[1:0] == 2'b00) ? 8'h0A : (r[2] ? {4'h0, r[11:8]} : r[19:12]);
      busCycle(r[20] & r[21], a, r[22], r[31:24], r[23] | r[3], "rand");
    end

    // R9: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; expReg = 4'b0101;
    #1 check("R9 mid-run reset", regOut(), 8'h05);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule